// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block is the digital control logic that sits around an analog low-supply comparator. Software reaches it over a simple register bus. It programs a threshold code that goes to the analog side, and it turns the monitor on with an enable bit. That control register accepts writes only after a 32-bit unlock key has been written to a separate key register. Writing any other value to the key register locks the control register again.

Once the monitor is enabled, a fixed settling window of 2002 bus clock cycles must pass before monitoring is valid. During that window the comparator output is ignored. When the window ends, a ready flag sets. From then on, a low-supply indication from the comparator latches an event flag. The flag holds until software clears it by writing zero to a clear register. The latched flag drives an interrupt request. It also drives a wake-up request while the system is in standby.

The comparator output is asynchronous and passes through a two-stage synchronizer. Both request outputs are registered.

Top module: `supmon_ctrl`

## Requirements
- R1: After reset the control register reads 0, so the monitor is off with threshold code 0. The key register reads 1, meaning locked. The status register reads 0. `irq` and `wake_req` are low. While the monitor is off, comparator activity never sets the event flag.
- R2: While the control register is locked, writes to it leave its value and the `thresh_code` port unchanged.
- R3: Writing exactly 0x1ACCE553 to the key register (address 1) unlocks the control register. Writing any other value to it locks the control register.
- R4: A read of the key register returns 0x00000000 when the control register is unlocked and 0x00000001 when it is locked.
- R5: The control register is at address 0. Bit 0 is the enable bit and bits 7:4 are the threshold code. The code is driven on `thresh_code` and reads back from the same field.
- R6: Status register (address 2), bit 0 is ready. Ready is set by the 2002nd rising clock edge after the edge that wrote enable = 1. A read sampled at that edge still returns ready = 0, and a read at the next edge returns 1.
- R7: While ready is 0, a comparator low indication does not set the event flag.
- R8: When the monitor is enabled and ready, a synchronized low indication latches the event flag, which is status bit 1. Writing 0 in bit 0 of the clear register (address 3) clears the flag. Writing 1 there has no effect. A new detection in the same cycle as a clear wins. The clear register reads 0.
- R9: `wake_req` is high when the flag is latched while enabled and ready and `standby` is high. It is low when `standby` is low.
- R10: The comparator input passes through two synchronizer flops. After it rises between clock edges, `irq` is still low after the 3rd edge and high after the 4th edge.
- R11: `irq` is the registered AND of the event flag, the enable bit and ready. It falls one edge after the flag is cleared.
- R12: Clearing the enable bit clears ready and resets the settling counter. Re-enabling restarts the full 2002-cycle wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read strobe |
| cmp_low_async | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| standby | input | 1 | System is in standby |
| thresh_code | output | 4 | Threshold select code to the analog side |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request for standby |

## Verification
On every cycle, the assertions check four relations:
- a locked control register never changes;
- ready never stays high once the enable bit is low;
- the event flag cannot rise while ready is low;
- `irq` follows a latched flag and `wake_req` implies `irq`.

Some behaviour only the bench scenarios can show:
- the exact 2002-edge settling point, and that disabling part way through restarts it;
- the four-edge synchronizer latency;
- that only the exact key value unlocks;
- the clear semantics, including that writing 1 to the clear register does nothing.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE553;
  localparam int unsigned SETTLE_CYCLES = 2002;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_KEY  = 2'd1,
    A_STAT = 2'd2,
    A_CLR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ready,
  input  logic              flag,
  output logic              ctrl_en,
  output logic [CODE_W-1:0] ctrl_code,
  output logic              unlocked,
  output logic              clr_req,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned CODE_LSB = 4;

  reg_addr_e   addr;
  logic        wr_strobe;
  logic [DATA_W-1:0] rd_mux;

  assign addr      = reg_addr_e'(bus_addr);
  assign wr_strobe = bus_sel && bus_wr;
  assign clr_req   = wr_strobe && (addr == A_CLR) && !bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked  <= 1'b0;
      ctrl_en   <= 1'b0;
      ctrl_code <= '0;
    end else if (wr_strobe) begin
      if (addr == A_KEY)
        unlocked <= (bus_wdata == DATA_W'(UNLOCK_KEY));
      if (addr == A_CTRL && unlocked) begin
        ctrl_en   <= bus_wdata[0];
        ctrl_code <= bus_wdata[CODE_LSB +: CODE_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[0]                 = ctrl_en;
        rd_mux[CODE_LSB +: CODE_W] = ctrl_code;
      end
      A_KEY:  rd_mux[0] = !unlocked;
      A_STAT: begin
        rd_mux[0] = ready;
        rd_mux[1] = flag;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    else                         bus_rdata <= '0;
  end
endmodule

// File: rtl/supmon_settle.sv
module supmon_settle #(
  parameter int unsigned WAIT = 2002
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(WAIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/supmon_detect.sv
module supmon_detect (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic low_sync,
  input  logic clr_req,
  input  logic standby,
  output logic flag,
  output logic irq,
  output logic wake_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      irq      <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      flag     <= (flag && !clr_req) || (armed && low_sync);
      irq      <= flag && armed;
      wake_req <= flag && armed && standby;
    end
  end
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned WAIT        = SETTLE_CYCLES,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp_low_async,
  input  logic              standby,
  output logic [CODE_W-1:0] thresh_code,
  output logic              irq,
  output logic              wake_req
);
  logic ctrl_en, ready, flag, unlocked, clr_req, low_sync;

  supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(cmp_low_async), .q(low_sync)
  );

  supmon_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ready(ready), .flag(flag),
    .ctrl_en(ctrl_en), .ctrl_code(thresh_code), .unlocked(unlocked),
    .clr_req(clr_req), .bus_rdata(bus_rdata)
  );

  supmon_settle #(.WAIT(WAIT)) u_settle (
    .clk(clk), .rst(rst), .enable(ctrl_en), .ready(ready)
  );

  supmon_detect u_detect (
    .clk(clk), .rst(rst), .armed(ctrl_en && ready), .low_sync(low_sync),
    .clr_req(clr_req), .standby(standby), .flag(flag), .irq(irq),
    .wake_req(wake_req)
  );
endmodule

// File: rtl/supmon_ctrl_chk.sv
module supmon_ctrl_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_en,
  input logic              ready,
  input logic              flag,
  input logic              unlocked,
  input logic              irq,
  input logic              wake_req,
  input logic [CODE_W-1:0] thresh_code
);
  p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> ($stable(ctrl_en) && $stable(thresh_code)));

  p_ready_drop_r12: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !ready);

  p_no_early_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (!ready && !flag) |=> !flag);

  p_irq_from_flag_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag));

  p_wake_implies_irq_r9: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> irq);
endmodule

bind supmon_ctrl supmon_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ready(ready), .flag(flag),
  .unlocked(unlocked), .irq(irq), .wake_req(wake_req),
  .thresh_code(thresh_code)
);

// File: tb/supmon_ctrl_test.sv
module supmon_ctrl_test;
  localparam int unsigned WAIT = 2002;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmp_low_async = 1'b0;
  logic        standby = 1'b0;
  logic [3:0]  thresh_code;
  logic        irq, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic mon_rd = 1'b0;

  always #4 clk = ~clk;

  supmon_ctrl uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_low_async(cmp_low_async), .standby(standby),
    .thresh_code(thresh_code), .irq(irq), .wake_req(wake_req)
  );

  // monitor: compares registered read data against queued expectations
  always @(posedge clk) mon_rd <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (mon_rd) begin
      item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL %s read with no expectation: actual %h expected none", "R0", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state, R4 locked read
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h1, "R4 key locked");
    rd(2'd2, 32'h0, "R1 status");
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake_req, 0);
    chk("R1 code", thresh_code, 0);

    // R2 locked writes ignored
    wr(2'd0, 32'h21);
    rd(2'd0, 32'h0, "R2 ctrl locked");
    chk("R2 code port", thresh_code, 0);

    // R3 near-miss key keeps lock, exact key unlocks
    wr(2'd1, 32'h1ACCE552);
    rd(2'd1, 32'h1, "R3 wrong key");
    wr(2'd1, 32'h1ACCE553);
    rd(2'd1, 32'h0, "R4 key unlocked");

    // R1 monitor off: comparator ignored
    cmp_low_async = 1'b1;
    repeat (10) @(posedge clk);
    rd(2'd2, 32'h0, "R1 off no detect");
    cmp_low_async = 1'b0;

    // R5 enable with code 2
    wr(2'd0, 32'h21);
    rd(2'd0, 32'h21, "R5 ctrl readback");
    chk("R5 code port", thresh_code, 4'h2);

    // R7 comparator active during settling
    cmp_low_async = 1'b1;
    repeat (600) @(posedge clk);
    rd(2'd2, 32'h0, "R7 settling ignores cmp");
    chk("R7 irq", irq, 0);
    cmp_low_async = 1'b0;
    repeat (5) @(posedge clk);

    // R12 disable mid-wait, then full restart; R6 exact edge
    wr(2'd0, 32'h20);
    rd(2'd2, 32'h0, "R12 ready cleared");
    wr(2'd0, 32'h21);
    repeat (WAIT - 1) @(posedge clk);
    rd(2'd2, 32'h0, "R6 R12 not ready at edge 2002 sample");
    rd(2'd2, 32'h1, "R6 ready after edge 2002");

    // lock again, R2 write ignored while locked
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h1, "R3 relock");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h21, "R2 ctrl held");

    // R10 latency, R11 irq, R9 no wake outside standby
    @(posedge clk); #1;
    cmp_low_async = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R10 irq low after 3 edges", irq, 0);
    @(posedge clk); #1;
    chk("R10 R11 irq high after 4 edges", irq, 1);
    chk("R9 no wake outside standby", wake_req, 0);
    rd(2'd2, 32'h3, "R8 flag latched");

    // R8 flag holds after comparator recovers; writing 1 does nothing
    cmp_low_async = 1'b0;
    repeat (4) @(posedge clk);
    rd(2'd2, 32'h3, "R8 flag held");
    wr(2'd3, 32'h1);
    rd(2'd2, 32'h3, "R8 clear with 1 ignored");
    chk("R8 irq still high", irq, 1);
    rd(2'd3, 32'h0, "R8 clear reg reads 0");
    wr(2'd3, 32'h0);
    rd(2'd2, 32'h1, "R8 flag cleared");
    chk("R11 irq falls", irq, 0);

    // R9 standby wake
    standby = 1'b1;
    @(posedge clk); #1;
    cmp_low_async = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R9 wake in standby", wake_req, 1);
    chk("R9 irq in standby", irq, 1);
    cmp_low_async = 1'b0;
    repeat (4) @(posedge clk);
    wr(2'd3, 32'h0);
    @(posedge clk); #1;
    chk("R9 wake drops on clear", wake_req, 0);
    standby = 1'b0;

    repeat (3) @(posedge clk);
    chk("R0 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule